// File: doc/BRIEF.md
# Indirect-Addressed Nibble Register Interface

This block is the 4-bit processor bus port of a four-line power feed controller. A processor reaches it through a chip select, separate read and write strobes, one address bit and an address-latch strobe. The address bit chooses between two ports. Port 0 is the indirect index port, which holds a 3-bit group index and an interrupt-enable bit. Port 1 is the data port, which writes the line-enable register directly and reads whichever group the index points at.

The readable groups are the per-line status words. These are low voltage, open loop, current overload and actual switch state, plus the line-enable register and the thermal register. The status words are sampled live on every read and are never stored here. All bus strobes are synchronized into the block clock. A write is committed once its strobe has been released. Read data come out of a register, together with an output-enable flag that an external pad uses to drive the shared data lines.

Top module: `nibble_bus_if`

## Requirements
- R1: The address bit is latched internally. The latch follows the address pin while the address-latch strobe is high and keeps its value while the strobe is low. Holding the strobe high permanently gives non-multiplexed operation.
- R2: A write with the latched address bit at 0 loads data bits 2..0 into the index register and data bit 3 into the interrupt-enable output `intEnable`.
- R3: A read with the latched address bit at 0 returns the overtemperature flag on bit 3 and the index register on bits 2..0.
- R4: A write with the latched address bit at 1 loads all four data bits into `lineEnable`.
- R5: A read with the latched address bit at 1 returns the group chosen by the index, sampled live: 000 low voltage, 001 open loop, 010 current overload, 011 switch state, 110 line-enable register, 111 thermal register.
- R6: `rdDataOe` is high only while chip select and read are both seen low. At all other times `rdDataOe` is low and `rdData` is 0000.
- R7: A data-port read with index 100 or 101 returns 0000.
- R8: Reset clears the index, the latched address bit, `intEnable` and `lineEnable`, and drops `rdDataOe`.
- R9: While read and write are both low, no register is loaded and the data lines are not driven.
- R10: A write takes effect only after its strobe rises, following the synchronizer delay. A write made with chip select high changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Asynchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addrPin | input | 1 | Port select address bit |
| aleStrobe | input | 1 | Address latch enable, transparent when high |
| wrNibble | input | 4 | Write data from the bus |
| lowVolt | input | 4 | Per-line low-voltage status |
| openLoop | input | 4 | Per-line open-loop status |
| overCur | input | 4 | Per-line current-overload status |
| swState | input | 4 | Per-line actual switch state |
| thermReg | input | 4 | Thermal register contents |
| overTemp | input | 1 | Device overtemperature flag |
| rdData | output | 4 | Registered read data |
| rdDataOe | output | 1 | Output enable for the data lines |
| lineEnable | output | 4 | Line-enable register |
| intEnable | output | 1 | Interrupt-enable bit |

## Verification
On every cycle, the assertions check four things. The address latch holds while its strobe is low. The index and line-enable registers change only on a committed write strobe, and the two write strobes never fire together. The output enable tracks the synchronized read condition, and reserved index codes read as zero. Only the bench scenarios can show the rest. These are the value mapping of each group code, the overtemperature flag on bit 3, the latched-address behaviour in multiplexed use, the conflicting-strobe and deselected-write cases, and the reset state seen through the bus.

// File: rtl/nbi_pkg.sv
package nbi_pkg;
  localparam int NIBBLE_W = 4;
  localparam int INDEX_W  = 3;

  typedef enum logic [INDEX_W-1:0] {
    GRP_LOWV   = 3'b000,
    GRP_OPEN   = 3'b001,
    GRP_OVCUR  = 3'b010,
    GRP_SWITCH = 3'b011,
    GRP_RSV4   = 3'b100,
    GRP_RSV5   = 3'b101,
    GRP_LINE   = 3'b110,
    GRP_THERM  = 3'b111
  } groupSel_e;

  typedef struct packed {
    logic loadIndex;
    logic loadLine;
    logic readEn;
    logic addrBit;
  } busStrobe_t;
endpackage

// File: rtl/nbi_ctrl.sv
module nbi_ctrl
  import nbi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csN,
  input  logic                rdN,
  input  logic                wrN,
  input  logic                addrPin,
  input  logic                aleStrobe,
  input  logic [NIBBLE_W-1:0] wrNibble,
  output busStrobe_t          strobe,
  output logic [NIBBLE_W-1:0] commitData
);
  localparam int BUS_W = 5 + NIBBLE_W;
  localparam logic [BUS_W-1:0] IDLE_BUS = {3'b111, 2'b00, {NIBBLE_W{1'b0}}};

  logic [SYNC_STAGES-1:0][BUS_W-1:0] syncPipe;
  logic [BUS_W-1:0] rawBus, syncBus;
  logic csS, rdS, wrS, aleS, addrS;
  logic [NIBBLE_W-1:0] dataS;
  logic addrLatch, wrActQ, wrAct, rdAct, commit;
  logic [NIBBLE_W-1:0] wrHold;

  assign rawBus = {csN, rdN, wrN, aleStrobe, addrPin, wrNibble};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= IDLE_BUS;
    end else begin
      syncPipe[0] <= rawBus;
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign syncBus = syncPipe[SYNC_STAGES-1];
  assign {csS, rdS, wrS, aleS, addrS, dataS} = syncBus;

  // conflicting strobes (both low) count as no access
  assign wrAct = !csS && !wrS && rdS;
  assign rdAct = !csS && !rdS && wrS;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      addrLatch <= 1'b0;
      wrActQ    <= 1'b0;
      wrHold    <= '0;
    end else begin
      if (aleS) addrLatch <= addrS;
      wrActQ <= wrAct;
      if (wrAct) wrHold <= dataS;
    end
  end

  assign commit = wrActQ && !wrAct;

  always_comb begin
    strobe.loadIndex = commit && !addrLatch;
    strobe.loadLine  = commit && addrLatch;
    strobe.readEn    = rdAct;
    strobe.addrBit   = addrLatch;
  end
  assign commitData = wrHold;

  // R1: latch holds while the strobe is low
  a_r1_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !aleS |=> $stable(addrLatch));
  // R9: a write commit only follows a cycle of a clean write
  a_r9_commit_clean: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadIndex || strobe.loadLine) |-> $past(!csS && !wrS && rdS));
endmodule

// File: rtl/nbi_datapath.sv
module nbi_datapath
  import nbi_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  busStrobe_t          strobe,
  input  logic [NIBBLE_W-1:0] commitData,
  input  logic [NIBBLE_W-1:0] lowVolt,
  input  logic [NIBBLE_W-1:0] openLoop,
  input  logic [NIBBLE_W-1:0] overCur,
  input  logic [NIBBLE_W-1:0] swState,
  input  logic [NIBBLE_W-1:0] thermReg,
  input  logic                overTemp,
  output logic [NIBBLE_W-1:0] rdData,
  output logic                rdDataOe,
  output logic [NIBBLE_W-1:0] lineEnable,
  output logic                intEnable
);
  logic [INDEX_W-1:0]  idxReg;
  logic [NIBBLE_W-1:0] groupWord, readWord;

  always_comb begin
    unique case (groupSel_e'(idxReg))
      GRP_LOWV:   groupWord = lowVolt;
      GRP_OPEN:   groupWord = openLoop;
      GRP_OVCUR:  groupWord = overCur;
      GRP_SWITCH: groupWord = swState;
      GRP_LINE:   groupWord = lineEnable;
      GRP_THERM:  groupWord = thermReg;
      default:    groupWord = '0;
    endcase
    readWord = strobe.addrBit ? groupWord : {overTemp, idxReg};
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      idxReg     <= '0;
      intEnable  <= 1'b0;
      lineEnable <= '0;
      rdData     <= '0;
      rdDataOe   <= 1'b0;
    end else begin
      if (strobe.loadIndex) begin
        idxReg    <= commitData[INDEX_W-1:0];
        intEnable <= commitData[NIBBLE_W-1];
      end
      if (strobe.loadLine) lineEnable <= commitData;
      rdDataOe <= strobe.readEn;
      rdData   <= strobe.readEn ? readWord : '0;
    end
  end

  // R2: index and mask bit move only on an index-port write
  a_r2_index_stable: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadIndex |=> ($stable(idxReg) && $stable(intEnable)));
  // R4: line-enable register moves only on a data-port write
  a_r4_line_stable: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadLine |=> $stable(lineEnable));
  // R6: released bus drives nothing
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !strobe.readEn |=> (!rdDataOe && rdData == '0));
  // R7: reserved codes read as zero
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (strobe.readEn && strobe.addrBit && idxReg[2:1] == 2'b10) |=> rdData == '0);
  // R10: the two write strobes are exclusive
  a_r10_one_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.loadIndex, strobe.loadLine}));
endmodule

// File: rtl/nibble_bus_if.sv
module nibble_bus_if
  import nbi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       addrPin,
  input  logic       aleStrobe,
  input  logic [3:0] wrNibble,
  input  logic [3:0] lowVolt,
  input  logic [3:0] openLoop,
  input  logic [3:0] overCur,
  input  logic [3:0] swState,
  input  logic [3:0] thermReg,
  input  logic       overTemp,
  output logic [3:0] rdData,
  output logic       rdDataOe,
  output logic [3:0] lineEnable,
  output logic       intEnable
);
  busStrobe_t          strobe;
  logic [NIBBLE_W-1:0] commitData;

  nbi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addrPin(addrPin), .aleStrobe(aleStrobe), .wrNibble(wrNibble),
    .strobe(strobe), .commitData(commitData)
  );

  nbi_datapath dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .commitData(commitData),
    .lowVolt(lowVolt), .openLoop(openLoop), .overCur(overCur),
    .swState(swState), .thermReg(thermReg), .overTemp(overTemp),
    .rdData(rdData), .rdDataOe(rdDataOe), .lineEnable(lineEnable),
    .intEnable(intEnable)
  );
endmodule

// File: tb/nibble_bus_if_tb.sv
module nibble_bus_if_tb_top;
  logic clk = 0, rst = 1;
  logic csN = 1, rdN = 1, wrN = 1, addrPin = 0, aleStrobe = 1;
  logic [3:0] wrNibble = 0;
  logic [3:0] lowVolt = 4'h3, openLoop = 4'h5, overCur = 4'h9, swState = 4'hC, thermReg = 4'hE;
  logic overTemp = 1;
  logic [3:0] rdData, lineEnable;
  logic rdDataOe, intEnable;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nibble_bus_if dut_i (.*);

  // {isWrite, addr, data, expected}
  localparam logic [9:0] VEC [0:18] = '{
    {1'b1,1'b0,4'h8,4'h0}, {1'b0,1'b0,4'h0,4'h8}, {1'b0,1'b1,4'h0,4'h3},
    {1'b1,1'b0,4'h1,4'h0}, {1'b0,1'b1,4'h0,4'h5},
    {1'b1,1'b0,4'h2,4'h0}, {1'b0,1'b1,4'h0,4'h9},
    {1'b1,1'b0,4'h3,4'h0}, {1'b0,1'b1,4'h0,4'hC},
    {1'b1,1'b1,4'hA,4'h0},
    {1'b1,1'b0,4'h6,4'h0}, {1'b0,1'b1,4'h0,4'hA},
    {1'b1,1'b0,4'h7,4'h0}, {1'b0,1'b1,4'h0,4'hE},
    {1'b1,1'b0,4'h4,4'h0}, {1'b0,1'b1,4'h0,4'h0},
    {1'b1,1'b0,4'h5,4'h0}, {1'b0,1'b1,4'h0,4'h0},
    {1'b0,1'b0,4'h0,4'hD}
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic a, input logic [3:0] d);
    @(negedge clk); addrPin = a; wrNibble = d; csN = 0; wrN = 0;
    repeat (4) @(negedge clk);
    wrN = 1; csN = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic busRead(input logic a, output logic [3:0] d, output logic oe);
    @(negedge clk); addrPin = a; csN = 0; rdN = 0;
    repeat (5) @(posedge clk);
    #1 d = rdData; oe = rdDataOe;
    @(negedge clk); rdN = 1; csN = 1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] d; logic oe;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    // R8 reset state
    check("R8 oe", {3'b0, rdDataOe}, 4'h0);
    check("R8 lineEnable", lineEnable, 4'h0);
    check("R8 intEnable", {3'b0, intEnable}, 4'h0);
    busRead(1'b0, d, oe);
    check("R3 R8 index cleared", d, 4'h8);
    check("R6 oe during read", {3'b0, oe}, 4'h1);
    check("R6 released", {3'b0, rdDataOe}, 4'h0);
    check("R6 released data", rdData, 4'h0);

    // vector table: R2 R3 R4 R5 R7
    foreach (VEC[i]) begin
      if (VEC[i][9]) begin
        busWrite(VEC[i][8], VEC[i][7:4]);
        if (i == 0) check("R2 intEnable set", {3'b0, intEnable}, 4'h1);
        if (i == 9) check("R4 lineEnable", lineEnable, 4'hA);
      end else begin
        busRead(VEC[i][8], d, oe);
        check($sformatf("R5/R7/R3 vector %0d", i), d, VEC[i][3:0]);
      end
    end
    check("R2 intEnable cleared", {3'b0, intEnable}, 4'h0);

    // R5 live sampling
    busWrite(1'b0, 4'h0);
    lowVolt = 4'h6;
    busRead(1'b1, d, oe);
    check("R5 live low voltage", d, 4'h6);

    // R10 write with chip select high changes nothing
    @(negedge clk); addrPin = 1; wrNibble = 4'h5; wrN = 0;
    repeat (4) @(negedge clk); wrN = 1; repeat (6) @(negedge clk);
    check("R10 deselected write", lineEnable, 4'hA);

    // R10 write not visible before strobe release
    @(negedge clk); addrPin = 1; wrNibble = 4'h3; csN = 0; wrN = 0;
    repeat (6) @(negedge clk);
    check("R10 not before release", lineEnable, 4'hA);
    wrN = 1; csN = 1; repeat (6) @(negedge clk);
    check("R10 after release", lineEnable, 4'h3);

    // R9 both strobes low: no load, no drive
    @(negedge clk); addrPin = 1; wrNibble = 4'hF; csN = 0; wrN = 0; rdN = 0;
    repeat (5) @(posedge clk); #1;
    check("R9 no drive", {3'b0, rdDataOe}, 4'h0);
    @(negedge clk); wrN = 1; rdN = 1; csN = 1; repeat (6) @(negedge clk);
    check("R9 no load", lineEnable, 4'h3);

    // R1 multiplexed: latch port 1, then move the pin
    @(negedge clk); aleStrobe = 1; addrPin = 1;
    repeat (4) @(negedge clk); aleStrobe = 0;
    repeat (4) @(negedge clk); addrPin = 0;
    @(negedge clk); csN = 0; rdN = 0;
    repeat (5) @(posedge clk); #1 d = rdData;
    @(negedge clk); rdN = 1; csN = 1; repeat (5) @(negedge clk);
    check("R1 latched port 1", d, 4'h6);

    // R8 reset mid-operation clears the latched address bit too
    @(negedge clk); rst = 1; repeat (2) @(negedge clk); rst = 0;
    repeat (2) @(negedge clk);
    check("R8 lineEnable after reset", lineEnable, 4'h0);
    addrPin = 1;
    @(negedge clk); csN = 0; rdN = 0;
    repeat (5) @(posedge clk); #1 d = rdData;
    @(negedge clk); rdN = 1; csN = 1; repeat (5) @(negedge clk);
    check("R8 R1 latch cleared", d, 4'h8);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule